// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the operand address for an 8-bit processor whose index pointer is a 16-bit pair: a high byte H and a low byte X, read together as H:X. Each request carries an addressing-mode code, the current H:X value and the one or two bytes that follow the opcode in the instruction stream. The block returns the 16-bit effective address and the instruction length in bytes. For the post-increment mode it also returns the incremented pointer together with a write strobe, so that the register file can commit the new H:X.

Five modes are served: index with no offset, index with post-increment, index plus an unsigned 8-bit offset, zero-page direct and full 16-bit extended. A request is a single-cycle `start` pulse. All results are registered and appear, with a one-cycle `done` pulse, on the cycle after the request. They then hold until the next request.

Top module: `idx_ea_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `done`, `hx_we`, `ea`, `len` and `hx_next` are all zero until the first request.
- R2: `done` is high in exactly the cycle that follows a cycle with `start` high, and low in every other cycle. Back-to-back requests give back-to-back results.
- R3: Mode code 0 (index, no offset): `ea` equals H:X and `len` is 1.
- R4: Mode code 1 (index, post-increment): `ea` equals the H:X value before the increment, `len` is 2, and `hx_next` equals H:X + 1 modulo 2^16. A carry out of X propagates into H, and 0xFFFF becomes 0x0000.
- R5: Mode code 2 (index, 8-bit offset): `ea` equals H:X plus `opnd_hi` taken as an unsigned byte, modulo 2^16, and `len` is 2. Offsets of 0x80 and above add, never subtract.
- R6: Mode code 3 (direct): `ea` equals {0x00, `opnd_hi`} and `len` is 2. Neither `opnd_lo` nor H:X has any effect on `ea`.
- R7: Mode code 4 (extended): `ea` equals {`opnd_hi`, `opnd_lo`}, with the first operand byte as the high byte, and `len` is 3.
- R8: `hx_we` is high only in the `done` cycle of a mode-1 request, for that single cycle. `hx_next` changes only on mode-1 requests.
- R9: Mode codes 5, 6 and 7 are undefined. They produce `ea` = 0 and `len` = 0, still pulse `done`, and never raise `hx_we`.
- R10: In cycles without a request, `ea` and `len` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request; the mode and operand inputs are sampled with it |
| mode | input | 3 | Addressing-mode code (0 to 4 defined) |
| hx | input | 16 | Current index pair, H in bits 15:8, X in bits 7:0 |
| opnd_hi | input | 8 | First byte after the opcode (offset, direct address or extended high byte) |
| opnd_lo | input | 8 | Second byte after the opcode (extended low byte) |
| done | output | 1 | Result valid pulse, one cycle after `start` |
| ea | output | 16 | Effective address |
| len | output | 2 | Instruction length in bytes |
| hx_we | output | 1 | Index pair write strobe for post-increment |
| hx_next | output | 16 | Incremented index pair |

## Verification
The checker relies on `mode`, `hx` and the operand bytes being sampled only on the clock edge where `start` is high, and on those inputs being known (not X) in that cycle. It also relies on reset being released synchronously. The driver changes all inputs only on the falling clock edge, drives every field with a defined value in a request cycle, and issues back-to-back requests with fresh values on each cycle. The undefined mode codes are driven on purpose, because their behaviour is specified rather than assumed away.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

   localparam int MODE_W = 3;
   localparam int LEN_W  = 2;

   typedef enum logic [MODE_W-1:0] {
      AM_IX   = 3'd0,
      AM_IXP  = 3'd1,
      AM_IX8  = 3'd2,
      AM_DIR  = 3'd3,
      AM_EXT  = 3'd4
   } am_e;

endpackage

// File: rtl/ea_add.sv
// Unsigned adder of a zero-extended narrow operand onto a wide base, wrapping.
module ea_add #(
   parameter int ADDR_W      = 16,
   parameter int OFF_W       = 8,
   parameter bit SPLIT_CARRY = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] sum
);
   localparam int HI_W = ADDR_W - OFF_W;

   if (OFF_W >= ADDR_W) begin : g_bad_w
      $error("ea_add: OFF_W must be narrower than ADDR_W");
   end

   if (SPLIT_CARRY) begin : g_split
      logic [OFF_W:0]  lo_sum;
      logic [HI_W-1:0] hi_sum;
      always_comb begin
         lo_sum = {1'b0, base[OFF_W-1:0]} + {1'b0, off};
         hi_sum = base[ADDR_W-1:OFF_W] + {{(HI_W-1){1'b0}}, lo_sum[OFF_W]};
      end
      assign sum = {hi_sum, lo_sum[OFF_W-1:0]};
   end else begin : g_flat
      assign sum = base + {{HI_W{1'b0}}, off};
   end
endmodule

// File: rtl/ea_sel.sv
// Mode decode: picks the address source and the length for each mode code.
module ea_sel
   import idx_ea_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [ADDR_W-1:0] hx,
   input  logic [ADDR_W-1:0] hx_off,
   input  logic [BYTE_W-1:0] opnd_hi,
   input  logic [BYTE_W-1:0] opnd_lo,
   output logic [ADDR_W-1:0] ea,
   output logic [LEN_W-1:0]  len,
   output logic              post
);
   localparam int PAD_W = ADDR_W - BYTE_W;

   always_comb begin
      ea   = '0;
      len  = '0;
      post = 1'b0;
      case (mode)
         AM_IX:  begin ea = hx;                        len = LEN_W'(1); end
         AM_IXP: begin ea = hx;                        len = LEN_W'(2); post = 1'b1; end
         AM_IX8: begin ea = hx_off;                    len = LEN_W'(2); end
         AM_DIR: begin ea = {{PAD_W{1'b0}}, opnd_hi};  len = LEN_W'(2); end
         AM_EXT: begin ea = {opnd_hi, opnd_lo};        len = LEN_W'(3); end
         default: begin ea = '0; len = '0; post = 1'b0; end
      endcase
   end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
   import idx_ea_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int BYTE_W      = 8,
   parameter bit SPLIT_CARRY = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [MODE_W-1:0]       mode,
   input  logic [ADDR_W-1:0]       hx,
   input  logic [BYTE_W-1:0]       opnd_hi,
   input  logic [BYTE_W-1:0]       opnd_lo,
   output logic                    done,
   output logic [ADDR_W-1:0]       ea,
   output logic [LEN_W-1:0]        len,
   output logic                    hx_we,
   output logic [ADDR_W-1:0]       hx_next
);
   if (ADDR_W != 2*BYTE_W) begin : g_bad_cfg
      $error("idx_ea_gen: ADDR_W must equal two operand bytes");
   end

   logic [ADDR_W-1:0] hx_off, hx_inc, sel_ea;
   logic [LEN_W-1:0]  sel_len;
   logic              sel_post;

   ea_add #(.ADDR_W(ADDR_W), .OFF_W(BYTE_W), .SPLIT_CARRY(SPLIT_CARRY)) u_off (
      .base(hx), .off(opnd_hi), .sum(hx_off)
   );

   ea_add #(.ADDR_W(ADDR_W), .OFF_W(BYTE_W), .SPLIT_CARRY(SPLIT_CARRY)) u_inc (
      .base(hx), .off(BYTE_W'(1)), .sum(hx_inc)
   );

   ea_sel #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_sel (
      .mode(mode), .hx(hx), .hx_off(hx_off),
      .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
      .ea(sel_ea), .len(sel_len), .post(sel_post)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done    <= 1'b0;
         hx_we   <= 1'b0;
         ea      <= '0;
         len     <= '0;
         hx_next <= '0;
      end else begin
         done  <= start;
         hx_we <= start & sel_post;
         if (start) begin
            ea  <= sel_ea;
            len <= sel_len;
            if (sel_post) hx_next <= hx_inc;
         end
      end
   end
endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk
   import idx_ea_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [MODE_W-1:0] mode,
   input logic [ADDR_W-1:0] hx,
   input logic [BYTE_W-1:0] opnd_hi,
   input logic [BYTE_W-1:0] opnd_lo,
   input logic              done,
   input logic [ADDR_W-1:0] ea,
   input logic [LEN_W-1:0]  len,
   input logic              hx_we,
   input logic [ADDR_W-1:0] hx_next
);
   p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);

   p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);

   p_ix_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == AM_IX) |=> (ea == $past(hx) && len == LEN_W'(1)));

   p_post_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == AM_IXP) |=> (hx_next == $past(hx) + ADDR_W'(1) && ea == $past(hx)));

   p_direct_zero_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == AM_DIR) |=> (ea[ADDR_W-1:BYTE_W] == '0 && ea[BYTE_W-1:0] == $past(opnd_hi)));

   p_ext_concat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == AM_EXT) |=> (ea == {$past(opnd_hi), $past(opnd_lo)} && len == LEN_W'(3)));

   p_we_only_post_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (hx_we == ($past(mode) == AM_IXP)));

   p_we_within_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hx_we |-> done);

   p_next_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && mode == AM_IXP) |=> $stable(hx_next));

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(ea) && $stable(len)));
endmodule

bind idx_ea_gen idx_ea_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/idx_ea_gen_test.sv
`timescale 1ns/100ps
module idx_ea_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = '0;
   logic [15:0] hx = '0;
   logic [7:0]  opnd_hi = '0, opnd_lo = '0;
   logic        done, hx_we;
   logic [15:0] ea, hx_next;
   logic [1:0]  len;

   int checks = 0;
   int failures = 0;
   bit running = 1'b0;
   bit finished = 1'b0;

   typedef struct {
      logic [15:0] ea;
      logic [1:0]  len;
      logic        we;
      logic [15:0] nx;
      string       tag;
   } exp_t;

   exp_t q[$];
   logic [15:0] last_ea = '0;
   logic [1:0]  last_len = '0;
   logic [15:0] last_nx = '0;

   always #2.5 clk = ~clk;

   idx_ea_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .hx(hx),
      .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .done(done), .ea(ea),
      .len(len), .hx_we(hx_we), .hx_next(hx_next)
   );

   function automatic exp_t model(input logic [2:0] m, input logic [15:0] h,
                                  input logic [7:0] b1, input logic [7:0] b2);
      exp_t e;
      e.we = 1'b0; e.nx = 16'h0; e.ea = 16'h0; e.len = 2'd0; e.tag = "R9";
      case (m)
         3'd0: begin e.ea = h; e.len = 2'd1; e.tag = "R3"; end
         3'd1: begin e.ea = h; e.len = 2'd2; e.we = 1'b1;
                     e.nx = 16'((32'(h) + 32'd1) % 32'd65536); e.tag = "R4"; end
         3'd2: begin e.ea = 16'((32'(h) + 32'(b1)) % 32'd65536); e.len = 2'd2; e.tag = "R5"; end
         3'd3: begin e.ea = {8'h00, b1}; e.len = 2'd2; e.tag = "R6"; end
         3'd4: begin e.ea = {b1, b2}; e.len = 2'd3; e.tag = "R7"; end
         default: ;
      endcase
      return e;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] m, input logic [15:0] h,
                        input logic [7:0] b1, input logic [7:0] b2);
      @(negedge clk);
      mode = m; hx = h; opnd_hi = b1; opnd_lo = b2; start = 1'b1;
      q.push_back(model(m, h, b1, b2));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start = 1'b0;
         mode = 3'(i); hx = 16'hDEAD; opnd_hi = 8'hA5; opnd_lo = 8'h5A;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (running) begin
         if (done) begin
            if (q.size() == 0) begin
               check(1'b0, "R2", "done without request", 16'(done), 16'h0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(ea == e.ea, e.tag, "ea", ea, e.ea);
               check(len == e.len, e.tag, "len", 16'(len), 16'(e.len));
               check(hx_we == e.we, "R8", "hx_we", 16'(hx_we), 16'(e.we));
               if (e.we) begin
                  check(hx_next == e.nx, "R4", "hx_next", hx_next, e.nx);
                  last_nx = e.nx;
               end else begin
                  check(hx_next == last_nx, "R8", "hx_next unchanged", hx_next, last_nx);
               end
               last_ea = e.ea; last_len = e.len;
            end
         end else begin
            check(hx_we == 1'b0, "R8", "hx_we outside done", 16'(hx_we), 16'h0);
            check(ea == last_ea && len == last_len, "R10", "hold ea",
                  ea, last_ea);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] lf;
      lf = 16'hACE1;
      repeat (4) @(negedge clk);
      // R1: reset state
      check(done == 1'b0 && hx_we == 1'b0, "R1", "flags in reset", {14'h0, done, hx_we}, 16'h0);
      check(ea == 16'h0 && len == 2'd0 && hx_next == 16'h0, "R1", "data in reset", ea, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && ea == 16'h0 && hx_next == 16'h0, "R1", "after release", ea, 16'h0);
      running = 1'b1;

      issue(3'd0, 16'h1234, 8'h77, 8'h88);       // R3
      idle(2);
      issue(3'd1, 16'hFFFF, 8'h00, 8'h00);       // R4 wrap
      idle(1);
      issue(3'd1, 16'h00FF, 8'h00, 8'h00);       // R4 carry into H
      idle(2);
      issue(3'd2, 16'hFFF0, 8'h20, 8'h00);       // R5 wrap
      issue(3'd2, 16'h10FF, 8'hFF, 8'h00);       // R5 carry
      issue(3'd2, 16'h1000, 8'h80, 8'h00);       // R5 unsigned
      idle(1);
      issue(3'd3, 16'hBEEF, 8'h5A, 8'hC3);       // R6 ignores opnd_lo and hx
      issue(3'd4, 16'h0000, 8'hF0, 8'h3B);       // R7
      issue(3'd5, 16'h4321, 8'h11, 8'h22);       // R9
      issue(3'd7, 16'hFFFF, 8'hFF, 8'hFF);       // R9
      idle(3);                                   // R10 hold
      for (int i = 0; i < 60; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         issue(lf[2:0], lf ^ 16'h5A3C, lf[15:8], lf[7:0]);
         if (lf[3]) idle(1);
      end
      idle(4);
      check(q.size() == 0, "R2", "all requests answered", 16'(q.size()), 16'h0);
      finish_run();
   end
endmodule